// File: doc/BRIEF.md
# Serial bootloader handshake engine

This block runs the host side of a byte-level exchange with a target's serial bootloader. After a start command it sends a synchronisation byte and waits for the target to acknowledge it. It then streams a framed message whose bytes it reads by index from an upstream buffer. Finally it waits for the target's answer and posts one of three results: success, negative acknowledge, or timeout. The UART that serialises the bytes (8 data bits, even parity, 9600 baud) sits outside this block. It meets the engine through a transmit valid/ready pair and a one-cycle receive strobe. Message content and checksums are also produced elsewhere.

The answer is awaited in one of two ways, chosen at start. In acknowledge mode a single byte is expected. In reply mode a multi-byte reply message is expected, and its length comes from one of its own header bytes. A free-running tick input paces two things. The first is the spacing between transmitted message bytes. The second is the wait for an answer, which is a base window repeated a set number of times. With a 1 µs tick the defaults give a gap of about 1.2 ms and a wait of 100 windows of 10 ms each.

Top module: `sbl_handshake_engine`

## Requirements
- R1: After reset, busy, done and tx_valid are 0 and result is 0 (no result).
- R2: A start in idle raises busy on the next cycle, clears result to 0, and the first byte offered on tx_data is the sync code 0x80.
- R3: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data holds its value. A byte is taken in a cycle where both are high.
- R4: If the target answers the sync with 0x90, the engine sends msg_len bytes. Byte i is the value of buf_data while buf_addr equals i, for i from 0 upward, and the bytes go out in that order. Each message byte is preceded by at least GAP_TICKS tick pulses.
- R5: In acknowledge mode (reply_mode=0), a 0x90 received after the message posts result 1 (success).
- R6: While the engine waits for a single acknowledge byte (after the sync, or after the message in acknowledge mode), a byte of 0xA0 or any value other than 0x90 posts result 2 (negative acknowledge). A rejected sync sends no message bytes.
- R7: If no answer arrives within WIN_TICKS×WIN_REPEAT tick pulses, the engine posts result 3 (timeout). Cycles without a tick pulse do not count toward this limit.
- R8: In reply mode (reply_mode=1), the byte at 0-based position RPL_LEN_POS of the reply gives a count L. The engine posts success on reply byte number RPL_HDR_BYTES+L+CSUM_BYTES and not before. A first reply byte of 0xA0 posts result 2.
- R9: done is a one-cycle pulse, and busy is low in the cycle when done is high. Result holds until the next start. A start while busy is ignored, so the mode and length latched at the first start stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timing pulse for gap and wait counting |
| start | input | 1 | Start command, taken only when idle |
| reply_mode | input | 1 | 0: single acknowledge byte, 1: reply message |
| msg_len | input | LW | Number of message bytes to send |
| buf_addr | output | LW | Index of the message byte being read |
| buf_data | input | 8 | Message byte at buf_addr |
| tx_valid | output | 1 | Byte on tx_data is offered to the UART |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | UART accepts the offered byte |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse when a result is posted |
| result | output | 2 | 0 none, 1 success, 2 negative acknowledge, 3 timeout |

## Verification
Two situations are hard to reach from the ports. The first is a wait that must outlast stalled time: the answer window has to survive many cycles with no tick and then still expire on ticks alone. The bench reaches this by holding the tick low for far longer than the whole window while the sync answer is pending, and only then letting ticks run again. The second is reply-mode completion, which depends on a length byte inside the reply itself. The bench feeds every reply byte except the last, confirms that no result has been posted, and then sends the final checksum byte. Stall patterns on tx_ready are applied on alternate table rows so that the hold behaviour of the transmit port is exercised together with gap spacing.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    localparam logic [7:0] SBL_SYNC = 8'h80;
    localparam logic [7:0] SBL_ACK  = 8'h90;
    localparam logic [7:0] SBL_NACK = 8'hA0;

    typedef enum logic [1:0] {
        RES_NONE    = 2'd0,
        RES_OK      = 2'd1,
        RES_NACK    = 2'd2,
        RES_TIMEOUT = 2'd3
    } sbl_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC_TX,
        ST_SYNC_WAIT,
        ST_GAP,
        ST_MSG_TX,
        ST_REPLY_WAIT
    } sbl_state_e;

endpackage

// File: rtl/sbl_tick_window.sv
module sbl_tick_window #(
    parameter int unsigned LIMIT  = 10000,
    parameter int unsigned REPEAT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam int unsigned RW = $clog2(REPEAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [RW-1:0] rep;
        logic          exp;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (!run) begin
            win_d = '0;
        end else if (tick && !win_q.exp) begin
            if (win_q.cnt == CW'(LIMIT - 1)) begin
                win_d.cnt = '0;
                win_d.rep = win_q.rep + RW'(1);
                if (win_q.rep == RW'(REPEAT - 1)) begin
                    win_d.exp = 1'b1;
                end
            end else begin
                win_d.cnt = win_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign expired = win_q.exp;

    // R7
    win_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_q.exp) |-> $past(run) && $past(tick));

    // R7
    rep_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_q.rep <= RW'(REPEAT));

endmodule

// File: rtl/sbl_reply_tracker.sv
module sbl_reply_tracker #(
    parameter int unsigned HDR_BYTES  = 4,
    parameter int unsigned LEN_POS    = 3,
    parameter int unsigned CSUM_BYTES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       first_byte,
    output logic       last_byte
);
    localparam int unsigned NW = $clog2(HDR_BYTES + CSUM_BYTES + 256);

    typedef struct packed {
        logic [NW-1:0] cnt;
        logic [7:0]    len;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [7:0]    eff_len;
    logic [NW-1:0] need;

    always_comb begin
        eff_len    = (trk_q.cnt == NW'(LEN_POS)) ? rx_data : trk_q.len;
        need       = NW'(HDR_BYTES + CSUM_BYTES) + NW'(eff_len);
        first_byte = active && rx_valid && (trk_q.cnt == '0);
        last_byte  = active && rx_valid && ((trk_q.cnt + NW'(1)) == need);
        trk_d      = trk_q;
        if (!active) begin
            trk_d = '0;
        end else if (rx_valid) begin
            trk_d.cnt = trk_q.cnt + NW'(1);
            if (trk_q.cnt == NW'(LEN_POS)) begin
                trk_d.len = rx_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // R8
    reply_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active && (trk_q.cnt > NW'(LEN_POS)) |->
            trk_q.cnt < (NW'(HDR_BYTES + CSUM_BYTES) + NW'(trk_q.len)));

endmodule

// File: rtl/sbl_handshake_engine.sv
module sbl_handshake_engine
    import sbl_pkg::*;
#(
    parameter int unsigned GAP_TICKS     = 1200,
    parameter int unsigned WIN_TICKS     = 10000,
    parameter int unsigned WIN_REPEAT    = 100,
    parameter int unsigned HDR_BYTES     = 8,
    parameter int unsigned DATA_MAX      = 256,
    parameter int unsigned CSUM_BYTES    = 2,
    parameter int unsigned RPL_HDR_BYTES = 4,
    parameter int unsigned RPL_LEN_POS   = 3,
    localparam int unsigned MSG_MAX      = HDR_BYTES + DATA_MAX + CSUM_BYTES,
    localparam int unsigned LW           = $clog2(MSG_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          reply_mode,
    input  logic [LW-1:0] msg_len,
    output logic [LW-1:0] buf_addr,
    input  logic [7:0]    buf_data,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result
);
    typedef struct packed {
        sbl_state_e    st;
        logic          mode;
        logic [LW-1:0] len;
        logic [LW-1:0] idx;
        sbl_result_e   res;
        logic          done;
    } eng_t;

    eng_t eng_d, eng_q;
    logic gap_run, gap_exp, win_run, win_exp;
    logic trk_active, trk_first, trk_last;

    assign gap_run    = (eng_q.st == ST_GAP);
    assign win_run    = (eng_q.st == ST_SYNC_WAIT) || (eng_q.st == ST_REPLY_WAIT);
    assign trk_active = (eng_q.st == ST_REPLY_WAIT) && eng_q.mode;

    sbl_tick_window #(.LIMIT(GAP_TICKS), .REPEAT(1)) i_gap_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gap_run),
        .tick    (tick),
        .expired (gap_exp)
    );

    sbl_tick_window #(.LIMIT(WIN_TICKS), .REPEAT(WIN_REPEAT)) i_wait_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (win_run),
        .tick    (tick),
        .expired (win_exp)
    );

    sbl_reply_tracker #(
        .HDR_BYTES  (RPL_HDR_BYTES),
        .LEN_POS    (RPL_LEN_POS),
        .CSUM_BYTES (CSUM_BYTES)
    ) i_reply_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (trk_active),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .first_byte (trk_first),
        .last_byte  (trk_last)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.st   = ST_SYNC_TX;
                    eng_d.mode = reply_mode;
                    eng_d.len  = msg_len;
                    eng_d.idx  = '0;
                    eng_d.res  = RES_NONE;
                end
            end
            ST_SYNC_TX: begin
                if (tx_ready) begin
                    eng_d.st = ST_SYNC_WAIT;
                end
            end
            ST_SYNC_WAIT: begin
                if (rx_valid) begin
                    if (rx_data == SBL_ACK) begin
                        eng_d.st = ST_GAP;
                    end else begin
                        eng_d.st   = ST_IDLE;
                        eng_d.res  = RES_NACK;
                        eng_d.done = 1'b1;
                    end
                end else if (win_exp) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.res  = RES_TIMEOUT;
                    eng_d.done = 1'b1;
                end
            end
            ST_GAP: begin
                if (gap_exp) begin
                    eng_d.st = (eng_q.idx == eng_q.len) ? ST_REPLY_WAIT : ST_MSG_TX;
                end
            end
            ST_MSG_TX: begin
                if (tx_ready) begin
                    eng_d.idx = eng_q.idx + LW'(1);
                    eng_d.st  = ST_GAP;
                end
            end
            ST_REPLY_WAIT: begin
                if (rx_valid && eng_q.mode) begin
                    if (trk_first && (rx_data == SBL_NACK)) begin
                        eng_d.st   = ST_IDLE;
                        eng_d.res  = RES_NACK;
                        eng_d.done = 1'b1;
                    end else if (trk_last) begin
                        eng_d.st   = ST_IDLE;
                        eng_d.res  = RES_OK;
                        eng_d.done = 1'b1;
                    end
                end else if (rx_valid) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.res  = (rx_data == SBL_ACK) ? RES_OK : RES_NACK;
                    eng_d.done = 1'b1;
                end else if (win_exp) begin
                    eng_d.st   = ST_IDLE;
                    eng_d.res  = RES_TIMEOUT;
                    eng_d.done = 1'b1;
                end
            end
            default: begin
                eng_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, mode: 1'b0, len: '0, idx: '0,
                       res: RES_NONE, done: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign buf_addr = eng_q.idx;
    assign tx_valid = (eng_q.st == ST_SYNC_TX) || (eng_q.st == ST_MSG_TX);
    assign tx_data  = (eng_q.st == ST_MSG_TX) ? buf_data : SBL_SYNC;
    assign busy     = (eng_q.st != ST_IDLE);
    assign done     = eng_q.done;
    assign result   = eng_q.res;

    // R2
    sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tx_valid && (tx_data == SBL_SYNC) && (result == RES_NONE));

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R5
    ack_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_REPLY_WAIT) && !eng_q.mode && rx_valid && (rx_data == SBL_ACK)
            |=> done && (result == RES_OK));

    // R6
    sync_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_SYNC_WAIT) && rx_valid && (rx_data != SBL_ACK)
            |=> done && (result == RES_NACK) && !tx_valid);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && (result != RES_NONE));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(eng_q.mode) && $stable(eng_q.len));

endmodule

// File: tb/test_sbl_handshake_engine.sv
module test_sbl_handshake_engine;
    localparam int GAP_T = 2;
    localparam int WIN_T = 10;
    localparam int WIN_R = 4;

    typedef struct packed {
        logic       mode;
        logic [8:0] len;
        logic       sync_go;
        logic [7:0] sync_b;
        logic       fin_go;
        logic [7:0] fin_b;
        logic [7:0] rlen;
        logic [1:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 9'd3, 1'b1, 8'h90, 1'b1, 8'h90, 8'd0, 2'd1},
        '{1'b0, 9'd2, 1'b1, 8'hA0, 1'b0, 8'h00, 8'd0, 2'd2},
        '{1'b0, 9'd1, 1'b1, 8'h90, 1'b1, 8'hA0, 8'd0, 2'd2},
        '{1'b0, 9'd2, 1'b1, 8'h90, 1'b1, 8'h55, 8'd0, 2'd2},
        '{1'b0, 9'd2, 1'b0, 8'h00, 1'b0, 8'h00, 8'd0, 2'd3},
        '{1'b0, 9'd2, 1'b1, 8'h90, 1'b0, 8'h00, 8'd0, 2'd3},
        '{1'b1, 9'd3, 1'b1, 8'h90, 1'b1, 8'h80, 8'd3, 2'd1},
        '{1'b1, 9'd1, 1'b1, 8'h90, 1'b1, 8'h80, 8'd0, 2'd1},
        '{1'b1, 9'd2, 1'b1, 8'h90, 1'b1, 8'hA0, 8'd0, 2'd2},
        '{1'b0, 9'd0, 1'b1, 8'h90, 1'b1, 8'h90, 8'd0, 2'd1},
        '{1'b0, 9'd2, 1'b1, 8'h33, 1'b0, 8'h00, 8'd0, 2'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       start = 1'b0;
    logic       reply_mode = 1'b0;
    logic [8:0] msg_len = '0;
    logic [8:0] buf_addr;
    logic [7:0] buf_data;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       busy, done;
    logic [1:0] result;
    logic       stall = 1'b0;

    int n_chk = 0, n_fail = 0;
    int mon_chk = 0, mon_fail = 0;
    int cyc = 0;
    int cap_n = 0;
    logic [7:0] cap [256];
    int cap_cyc [256];
    int done_n = 0;
    logic [1:0] last_res = '0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    int wd = 0;

    function automatic logic [7:0] bufpat(input logic [8:0] a);
        return a[7:0] * 8'd29 + 8'h11;
    endfunction

    assign buf_data = bufpat(buf_addr);

    sbl_handshake_engine #(
        .GAP_TICKS  (GAP_T),
        .WIN_TICKS  (WIN_T),
        .WIN_REPEAT (WIN_R)
    ) i_sbl_handshake_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .start      (start),
        .reply_mode (reply_mode),
        .msg_len    (msg_len),
        .buf_addr   (buf_addr),
        .buf_data   (buf_data),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .busy       (busy),
        .done       (done),
        .result     (result)
    );

    initial forever #4 clk = ~clk;

    always @(posedge clk) begin
        #2;
        tx_ready = stall ? ((cyc % 3) == 0) : 1'b1;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (prev_stall) begin
                mon_chk = mon_chk + 1;
                if (!(tx_valid && tx_data == prev_data)) begin
                    mon_fail = mon_fail + 1;
                    $display("FAIL R3 hold: actual valid=%0d data=%0h expected valid=1 data=%0h",
                             tx_valid, tx_data, prev_data);
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            if (tx_valid && tx_ready && cap_n < 256) begin
                cap[cap_n]     = tx_data;
                cap_cyc[cap_n] = cyc;
                cap_n          = cap_n + 1;
            end
            if (done) begin
                done_n   = done_n + 1;
                last_res = result;
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + mon_chk, n_fail + mon_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", wd);
            report();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic m, input logic [8:0] l);
        @(posedge clk); #2;
        start = 1'b1; reply_mode = m; msg_len = l;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(posedge clk); #2;
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk); #2;
        rx_valid = 1'b0;
    endtask

    task automatic wait_cap(input int n, input int lim);
        int k = 0;
        while (cap_n < n && k < lim) begin
            @(posedge clk);
            k++;
        end
    endtask

    task automatic wait_done(input int n, input int lim);
        int k = 0;
        while (done_n < n && k < lim) begin
            @(posedge clk);
            k++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int bc, bd;
        string tag;
        bc = cap_n;
        bd = done_n;
        if (v.mode && v.sync_go && v.sync_b == 8'h90) tag = "R8";
        else if (v.exp == 2'd2) tag = "R6";
        else if (v.exp == 2'd3) tag = "R7";
        else tag = "R5";
        pulse_start(v.mode, v.len);
        wait_cap(bc + 1, 300);
        check(cap_n > bc && cap[bc] == 8'h80, "R2 sync byte", int'(cap[bc]), 8'h80);
        if (v.sync_go) begin
            repeat (3) @(posedge clk);
            send_rx(v.sync_b);
        end
        if (v.sync_go && v.sync_b == 8'h90) begin
            wait_cap(bc + 1 + int'(v.len), 600);
            check(cap_n == bc + 1 + int'(v.len), "R4 byte count", cap_n - bc - 1, int'(v.len));
            for (int i = 0; i < int'(v.len); i++) begin
                check(cap[bc + 1 + i] == bufpat(9'(i)), "R4 byte value",
                      int'(cap[bc + 1 + i]), int'(bufpat(9'(i))));
                if (i > 0)
                    check(cap_cyc[bc + 1 + i] - cap_cyc[bc + i] > GAP_T, "R4 gap",
                          cap_cyc[bc + 1 + i] - cap_cyc[bc + i], GAP_T + 1);
            end
            repeat (GAP_T + 6) @(posedge clk);
            if (v.fin_go) begin
                if (!v.mode || v.fin_b == 8'hA0) begin
                    send_rx(v.fin_b);
                end else begin
                    send_rx(v.fin_b);
                    send_rx(8'h11);
                    send_rx(8'h22);
                    send_rx(v.rlen);
                    for (int i = 0; i < int'(v.rlen); i++) send_rx(8'(i + 1));
                    send_rx(8'hC1);
                    repeat (2) @(posedge clk);
                    check(done_n == bd && busy, "R8 not early", done_n - bd, 0);
                    send_rx(8'hC2);
                end
            end
        end else begin
            repeat (4) @(posedge clk);
            check(cap_n == bc + 1, "R6 no message after rejected sync", cap_n - bc, 1);
        end
        wait_done(bd + 1, 400);
        @(negedge clk);
        check(done_n == bd + 1, {tag, " done count"}, done_n - bd, 1);
        check(last_res == v.exp, {tag, " result"}, int'(last_res), int'(v.exp));
        check(!busy && result == v.exp, "R9 result held", int'(result), int'(v.exp));
    endtask

    initial begin
        int bc, bd;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !tx_valid && result == 2'd0, "R1 reset outputs",
              {busy, done, tx_valid, result}, 0);

        for (int k = 0; k < NV; k++) begin
            stall = (k % 2) == 1;
            run_vec(VECS[k]);
            repeat (3) @(posedge clk);
        end
        stall = 1'b0;

        // R9: start while busy is ignored; result cleared during busy
        bc = cap_n; bd = done_n;
        pulse_start(1'b0, 9'd1);
        wait_cap(bc + 1, 300);
        @(negedge clk);
        check(busy && result == 2'd0, "R9 result cleared while busy", int'(result), 0);
        pulse_start(1'b1, 9'd5);
        send_rx(8'h90);
        wait_cap(bc + 2, 300);
        repeat (GAP_T + 6) @(posedge clk);
        send_rx(8'h90);
        wait_done(bd + 1, 200);
        repeat (10) @(negedge clk);
        check(cap_n == bc + 2, "R9 length kept", cap_n - bc, 2);
        check(done_n == bd + 1, "R9 single done pulse", done_n - bd, 1);
        check(result == 2'd1 && !busy, "R9 first mode kept", int'(result), 1);

        // R7: cycles without tick do not advance the wait
        bc = cap_n; bd = done_n;
        pulse_start(1'b0, 9'd0);
        wait_cap(bc + 1, 300);
        @(posedge clk); #2 tick_en = 1'b0;
        repeat (WIN_T * WIN_R * 3) @(posedge clk);
        @(negedge clk);
        check(busy && done_n == bd, "R7 no timeout without ticks", done_n - bd, 0);
        @(posedge clk); #2 tick_en = 1'b1;
        wait_done(bd + 1, 400);
        @(negedge clk);
        check(done_n == bd + 1 && last_res == 2'd3, "R7 timeout after ticks", int'(last_res), 3);

        report();
    end
endmodule